// File: doc/BRIEF.md
# Mailbox Transmit Priority Scheduler

This block keeps 32 transmit mailboxes and decides which pending one is handed to the bus transmitter next. Software configures each mailbox through a write port. The configuration is an enable bit, a direction bit, a 5-bit priority level, an identifier, a length code and two 32-bit data words. Software then raises request bits with a mask write. The scheduler picks the mailbox with the highest priority level. When levels are equal, the higher mailbox index wins. The block offers that frame's fields to the transmitter through a valid/ready handshake and waits for the transmitter's one-cycle done pulse.

On the done pulse the block finishes the mailbox in a single cycle. It clears the request bit, sets the acknowledge bit and stores the value of a free-running counter as that mailbox's timestamp. Software clears acknowledge bits by writing ones. It reads any mailbox timestamp through an index port. A frame in flight is never pre-empted. A new winner is chosen only after the current frame completes.

Top module: `mbox_tx_sched`

## Requirements
- R1: After reset, reqVec and ackVec are all zero, txValid is 0, and every timestamp reads 0.
- R2: A mailbox competes only when its enable bit is 1 and its direction bit is 0 (transmit). A requested mailbox that is disabled or set to receive (direction 1) stays pending and is never offered, and its acknowledge bit stays 0.
- R3: Among competing mailboxes, the one with the largest priority level (0 lowest, 31 highest) is offered first.
- R4: Competing mailboxes with equal priority level are offered from the highest index down to the lowest.
- R5: When every request bit is raised in one write, each requested mailbox is sent exactly once. On each done pulse, the request bit of the sent mailbox clears and its acknowledge bit sets at the same clock edge.
- R6: Once a mailbox is offered, no other mailbox is offered until its done pulse. This holds even if a higher-priority request appears meanwhile, and txValid is 0 between the accepted handshake and the done pulse.
- R7: txValid, once high, stays high with txIdx and all frame fields unchanged until txReady is sampled high.
- R8: Writing ackClrMask with ackClrWe clears every acknowledge bit set in the mask. A completion on the same edge wins: that mailbox's acknowledge bit ends up set.
- R9: On the done pulse, the current value of a counter that increments on every clock is written to the sent mailbox's timestamp. Two timestamps therefore differ by the number of clock cycles between their done pulses.
- R10: txLen carries the stored 4-bit length code, limited to 8. A stored code above 8 is sent as 8.
- R11: A request-set write to a mailbox on the same edge as its completion leaves the request pending, and that mailbox is offered again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Writes the configuration of mailbox cfgIdx |
| cfgIdx | input | 5 | Mailbox index for the configuration write |
| cfgEnable | input | 1 | Enable bit to store |
| cfgDir | input | 1 | Direction bit to store (0 transmit, 1 receive) |
| cfgPrio | input | 5 | Priority level to store |
| cfgId | input | 29 | Identifier to store |
| cfgLen | input | 4 | Length code to store |
| cfgDataLo | input | 32 | Low data word to store |
| cfgDataHi | input | 32 | High data word to store |
| reqSetWe | input | 1 | Sets the request bits given in reqSetMask |
| reqSetMask | input | 32 | Request bits to set |
| ackClrWe | input | 1 | Clears the acknowledge bits given in ackClrMask |
| ackClrMask | input | 32 | Acknowledge bits to clear |
| tsIdx | input | 5 | Mailbox whose timestamp is read |
| tsData | output | 32 | Timestamp of mailbox tsIdx |
| reqVec | output | 32 | Pending request bits |
| ackVec | output | 32 | Acknowledge bits |
| txValid | output | 1 | A frame is offered to the transmitter |
| txReady | input | 1 | Transmitter accepts the offered frame |
| txIdx | output | 5 | Index of the offered mailbox |
| txId | output | 29 | Identifier of the offered frame |
| txLen | output | 4 | Length code of the offered frame, limited to 8 |
| txDataLo | output | 32 | Low data word of the offered frame |
| txDataHi | output | 32 | High data word of the offered frame |
| txDone | input | 1 | One-cycle pulse: the accepted frame has completed |

## Verification
Completion of a frame can fall in the same cycle as a software write to that mailbox's registers. Completion clears the request bit and sets the acknowledge bit. In that cycle software may set the same request bit again and write a one to clear the same acknowledge bit. The bench provokes this by driving both writes during the done pulse. The result is judged correct when the request is still pending, the acknowledge bit is set, and the same mailbox is offered and completed a second time with a timestamp that fits the cycle count.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  // scheduler sequencing states
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_OFFER  = 2'd1,
    ST_FLIGHT = 2'd2
  } mbxStateE;

  // strobes from control to datapath
  typedef struct packed {
    logic commit;  // finish current mailbox: clear request, set acknowledge
    logic stamp;   // capture the free-running counter for the current mailbox
  } mbxStrobeT;

endpackage

// File: rtl/mbx_pick.sv
module mbx_pick #(
  parameter int MBX_N  = 32,
  parameter int PRIO_W = 5,
  parameter int IDX_W  = 5
) (
  input  logic [MBX_N-1:0]        eligVec,
  input  logic [MBX_N*PRIO_W-1:0] prioFlat,
  output logic                    anyElig,
  output logic [IDX_W-1:0]        winIdx
);

  logic [PRIO_W-1:0] bestPrio;

  // ascending scan with >= lets a later (higher) index win a tie
  always_comb begin
    anyElig  = 1'b0;
    winIdx   = '0;
    bestPrio = '0;
    for (int i = 0; i < MBX_N; i++) begin
      if (eligVec[i] && (!anyElig || prioFlat[i*PRIO_W +: PRIO_W] >= bestPrio)) begin
        anyElig  = 1'b1;
        winIdx   = IDX_W'(i);
        bestPrio = prioFlat[i*PRIO_W +: PRIO_W];
      end
    end
  end

endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             anyElig,
  input  logic [IDX_W-1:0] winIdx,
  input  logic             txReady,
  input  logic             txDone,
  output logic             txValid,
  output logic [IDX_W-1:0] curIdx,
  output mbxStrobeT        strobe
);

  mbxStateE state;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      curIdx <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (anyElig) begin
            curIdx <= winIdx;
            state  <= ST_OFFER;
          end
        end
        ST_OFFER: begin
          if (txReady) state <= ST_FLIGHT;
        end
        ST_FLIGHT: begin
          if (txDone) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    txValid       = (state == ST_OFFER);
    strobe.commit = (state == ST_FLIGHT) && txDone;
    strobe.stamp  = (state == ST_FLIGHT) && txDone;
  end

endmodule

// File: rtl/mbx_dp.sv
module mbx_dp
  import mbx_pkg::*;
#(
  parameter int MBX_N   = 32,
  parameter int PRIO_W  = 5,
  parameter int ID_W    = 29,
  parameter int LEN_W   = 4,
  parameter int DATA_W  = 32,
  parameter int TS_W    = 32,
  parameter int MAX_LEN = 8,
  parameter int IDX_W   = 5
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cfgWe,
  input  logic [IDX_W-1:0]        cfgIdx,
  input  logic                    cfgEnable,
  input  logic                    cfgDir,
  input  logic [PRIO_W-1:0]       cfgPrio,
  input  logic [ID_W-1:0]         cfgId,
  input  logic [LEN_W-1:0]        cfgLen,
  input  logic [DATA_W-1:0]       cfgDataLo,
  input  logic [DATA_W-1:0]       cfgDataHi,
  input  logic                    reqSetWe,
  input  logic [MBX_N-1:0]        reqSetMask,
  input  logic                    ackClrWe,
  input  logic [MBX_N-1:0]        ackClrMask,
  input  logic [IDX_W-1:0]        tsIdx,
  input  mbxStrobeT               strobe,
  input  logic [IDX_W-1:0]        curIdx,
  output logic [TS_W-1:0]         tsData,
  output logic [MBX_N-1:0]        reqVec,
  output logic [MBX_N-1:0]        ackVec,
  output logic [MBX_N-1:0]        eligVec,
  output logic [MBX_N*PRIO_W-1:0] prioFlat,
  output logic [ID_W-1:0]         txId,
  output logic [LEN_W-1:0]        txLen,
  output logic [DATA_W-1:0]       txDataLo,
  output logic [DATA_W-1:0]       txDataHi
);

  localparam logic [LEN_W-1:0] LEN_CAP = LEN_W'(MAX_LEN);

  logic [ID_W-1:0]   idArr  [MBX_N];
  logic [LEN_W-1:0]  lenArr [MBX_N];
  logic [DATA_W-1:0] loArr  [MBX_N];
  logic [DATA_W-1:0] hiArr  [MBX_N];
  logic [TS_W-1:0]   tsArr  [MBX_N];
  logic [TS_W-1:0]   tickCount;
  logic [MBX_N-1:0]  reqNext, ackNext;

  // free-running timestamp counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tickCount <= '0;
    else       tickCount <= tickCount + 1'b1;
  end

  // per-mailbox storage
  for (genvar g = 0; g < MBX_N; g++) begin : gEntry
    logic              enQ, dirQ;
    logic [PRIO_W-1:0] prioQ;
    logic [ID_W-1:0]   idQ;
    logic [LEN_W-1:0]  lenQ;
    logic [DATA_W-1:0] loQ, hiQ;
    logic [TS_W-1:0]   tsQ;
    logic              cfgHit, tsHit;

    assign cfgHit = cfgWe && (cfgIdx == IDX_W'(g));
    assign tsHit  = strobe.stamp && (curIdx == IDX_W'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        enQ   <= 1'b0;
        dirQ  <= 1'b0;
        prioQ <= '0;
        idQ   <= '0;
        lenQ  <= '0;
        loQ   <= '0;
        hiQ   <= '0;
        tsQ   <= '0;
      end else begin
        if (cfgHit) begin
          enQ   <= cfgEnable;
          dirQ  <= cfgDir;
          prioQ <= cfgPrio;
          idQ   <= cfgId;
          lenQ  <= cfgLen;
          loQ   <= cfgDataLo;
          hiQ   <= cfgDataHi;
        end
        if (tsHit) tsQ <= tickCount;
      end
    end

    assign eligVec[g]                    = reqVec[g] & enQ & ~dirQ;
    assign prioFlat[g*PRIO_W +: PRIO_W] = prioQ;
    assign idArr[g]                      = idQ;
    assign lenArr[g]                     = lenQ;
    assign loArr[g]                      = loQ;
    assign hiArr[g]                      = hiQ;
    assign tsArr[g]                      = tsQ;
  end

  // request and acknowledge vectors: software set beats completion clear,
  // completion set beats software clear
  always_comb begin
    reqNext = reqVec;
    if (strobe.commit) reqNext[curIdx] = 1'b0;
    if (reqSetWe)      reqNext = reqNext | reqSetMask;
    ackNext = ackVec;
    if (ackClrWe)      ackNext = ackNext & ~ackClrMask;
    if (strobe.commit) ackNext[curIdx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqVec <= '0;
      ackVec <= '0;
    end else begin
      reqVec <= reqNext;
      ackVec <= ackNext;
    end
  end

  // frame fields of the current mailbox
  always_comb begin
    txId     = idArr[curIdx];
    txDataLo = loArr[curIdx];
    txDataHi = hiArr[curIdx];
    txLen    = (lenArr[curIdx] > LEN_CAP) ? LEN_CAP : lenArr[curIdx];
    tsData   = tsArr[tsIdx];
  end

endmodule

// File: rtl/mbox_tx_sched.sv
module mbox_tx_sched
  import mbx_pkg::*;
#(
  parameter int MBX_N   = 32,
  parameter int PRIO_W  = 5,
  parameter int ID_W    = 29,
  parameter int LEN_W   = 4,
  parameter int DATA_W  = 32,
  parameter int TS_W    = 32,
  parameter int MAX_LEN = 8,
  parameter int IDX_W   = $clog2(MBX_N)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [IDX_W-1:0]  cfgIdx,
  input  logic              cfgEnable,
  input  logic              cfgDir,
  input  logic [PRIO_W-1:0] cfgPrio,
  input  logic [ID_W-1:0]   cfgId,
  input  logic [LEN_W-1:0]  cfgLen,
  input  logic [DATA_W-1:0] cfgDataLo,
  input  logic [DATA_W-1:0] cfgDataHi,
  input  logic              reqSetWe,
  input  logic [MBX_N-1:0]  reqSetMask,
  input  logic              ackClrWe,
  input  logic [MBX_N-1:0]  ackClrMask,
  input  logic [IDX_W-1:0]  tsIdx,
  output logic [TS_W-1:0]   tsData,
  output logic [MBX_N-1:0]  reqVec,
  output logic [MBX_N-1:0]  ackVec,
  output logic              txValid,
  input  logic              txReady,
  output logic [IDX_W-1:0]  txIdx,
  output logic [ID_W-1:0]   txId,
  output logic [LEN_W-1:0]  txLen,
  output logic [DATA_W-1:0] txDataLo,
  output logic [DATA_W-1:0] txDataHi,
  input  logic              txDone
);

  logic [MBX_N-1:0]        eligVec;
  logic [MBX_N*PRIO_W-1:0] prioFlat;
  logic                    anyElig;
  logic [IDX_W-1:0]        winIdx;
  logic [IDX_W-1:0]        curIdx;
  mbxStrobeT               strobe;

  mbx_dp #(
    .MBX_N(MBX_N), .PRIO_W(PRIO_W), .ID_W(ID_W), .LEN_W(LEN_W),
    .DATA_W(DATA_W), .TS_W(TS_W), .MAX_LEN(MAX_LEN), .IDX_W(IDX_W)
  ) uDp (
    .clk(clk), .rstN(rstN),
    .cfgWe(cfgWe), .cfgIdx(cfgIdx), .cfgEnable(cfgEnable), .cfgDir(cfgDir),
    .cfgPrio(cfgPrio), .cfgId(cfgId), .cfgLen(cfgLen),
    .cfgDataLo(cfgDataLo), .cfgDataHi(cfgDataHi),
    .reqSetWe(reqSetWe), .reqSetMask(reqSetMask),
    .ackClrWe(ackClrWe), .ackClrMask(ackClrMask),
    .tsIdx(tsIdx), .strobe(strobe), .curIdx(curIdx),
    .tsData(tsData), .reqVec(reqVec), .ackVec(ackVec),
    .eligVec(eligVec), .prioFlat(prioFlat),
    .txId(txId), .txLen(txLen), .txDataLo(txDataLo), .txDataHi(txDataHi)
  );

  mbx_pick #(.MBX_N(MBX_N), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) uPick (
    .eligVec(eligVec), .prioFlat(prioFlat),
    .anyElig(anyElig), .winIdx(winIdx)
  );

  mbx_ctrl #(.IDX_W(IDX_W)) uCtrl (
    .clk(clk), .rstN(rstN), .anyElig(anyElig), .winIdx(winIdx),
    .txReady(txReady), .txDone(txDone),
    .txValid(txValid), .curIdx(curIdx), .strobe(strobe)
  );

  assign txIdx = curIdx;

endmodule

// File: rtl/mbox_tx_sched_chk.sv
module mbox_tx_sched_chk #(
  parameter int MBX_N   = 32,
  parameter int LEN_W   = 4,
  parameter int MAX_LEN = 8,
  parameter int IDX_W   = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic [MBX_N-1:0] reqVec,
  input logic [MBX_N-1:0] ackVec,
  input logic             txValid,
  input logic             txReady,
  input logic [IDX_W-1:0] txIdx,
  input logic [LEN_W-1:0] txLen
);

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    txValid && !txReady |=> txValid && $stable(txIdx)); // R7

  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rstN)
    txValid && txReady |=> !txValid); // R6

  AST_ACK_FROM_REQ: assert property (@(posedge clk) disable iff (!rstN)
    ((ackVec & ~$past(ackVec)) & ~$past(reqVec)) == '0); // R5

  AST_SINGLE_ACK: assert property (@(posedge clk) disable iff (!rstN)
    $countones(ackVec & ~$past(ackVec)) <= 1); // R5

  AST_REQ_DROP_ACK: assert property (@(posedge clk) disable iff (!rstN)
    ((~reqVec & $past(reqVec)) & ~ackVec) == '0); // R5

  AST_LEN_CAP: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> (txLen <= LEN_W'(MAX_LEN))); // R10

endmodule

bind mbox_tx_sched mbox_tx_sched_chk #(
  .MBX_N(MBX_N), .LEN_W(LEN_W), .MAX_LEN(MAX_LEN), .IDX_W(IDX_W)
) uChk (
  .clk(clk), .rstN(rstN), .reqVec(reqVec), .ackVec(ackVec),
  .txValid(txValid), .txReady(txReady), .txIdx(txIdx), .txLen(txLen)
);

// File: tb/sim_mbox_tx_sched.sv
module sim_mbox_tx_sched;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rstN;
  logic        cfgWe, cfgEnable, cfgDir;
  logic [4:0]  cfgIdx, cfgPrio, tsIdx;
  logic [28:0] cfgId;
  logic [3:0]  cfgLen;
  logic [31:0] cfgDataLo, cfgDataHi;
  logic        reqSetWe, ackClrWe;
  logic [31:0] reqSetMask, ackClrMask;
  logic [31:0] tsData, reqVec, ackVec;
  logic        txValid, txReady, txDone;
  logic [4:0]  txIdx;
  logic [28:0] txId;
  logic [3:0]  txLen;
  logic [31:0] txDataLo, txDataHi;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int bPrio [32];
  int bLen  [32];
  bit haveLast = 0;
  logic [31:0] lastTs;
  int lastCyc;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mbox_tx_sched u0 (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgIdx(cfgIdx), .cfgEnable(cfgEnable),
    .cfgDir(cfgDir), .cfgPrio(cfgPrio), .cfgId(cfgId), .cfgLen(cfgLen),
    .cfgDataLo(cfgDataLo), .cfgDataHi(cfgDataHi), .reqSetWe(reqSetWe),
    .reqSetMask(reqSetMask), .ackClrWe(ackClrWe), .ackClrMask(ackClrMask),
    .tsIdx(tsIdx), .tsData(tsData), .reqVec(reqVec), .ackVec(ackVec),
    .txValid(txValid), .txReady(txReady), .txIdx(txIdx), .txId(txId),
    .txLen(txLen), .txDataLo(txDataLo), .txDataHi(txDataHi), .txDone(txDone)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [28:0] expId(input int i);
    return 29'h0ABC000 + 29'(i);
  endfunction
  function automatic logic [31:0] expLo(input int i);
    return 32'h5000_0000 + 32'(i);
  endfunction

  task automatic cfg(input int i, input bit en, input bit dir, input int prio, input int len);
    cfgIdx = 5'(i); cfgEnable = en; cfgDir = dir; cfgPrio = 5'(prio);
    cfgId = expId(i); cfgLen = 4'(len); cfgDataLo = expLo(i); cfgDataHi = ~expLo(i);
    cfgWe = 1'b1;
    @(negedge clk);
    cfgWe = 1'b0;
    bPrio[i] = prio; bLen[i] = len;
  endtask

  task automatic setReq(input logic [31:0] m);
    reqSetWe = 1'b1; reqSetMask = m;
    @(negedge clk);
    reqSetWe = 1'b0; reqSetMask = '0;
  endtask

  task automatic clrAck(input logic [31:0] m);
    ackClrWe = 1'b1; ackClrMask = m;
    @(negedge clk);
    ackClrWe = 1'b0; ackClrMask = '0;
  endtask

  // wait for an offer of mailbox idx and carry it to completion
  task automatic serve(input int idx, input bit clash, input string tag);
    int w;
    int el;
    logic [31:0] ts;
    w = 0;
    while (!txValid && w < 60) begin @(negedge clk); w++; end
    check(txValid === 1'b1, {tag, " offer"}, txValid, 1);
    check(txIdx == 5'(idx), {tag, " order"}, txIdx, idx);
    check(txId == expId(idx) && txDataLo == expLo(idx) && txDataHi == ~expLo(idx),
          "R7 fields", txDataLo, expLo(idx));
    el = (bLen[idx] > 8) ? 8 : bLen[idx];
    check(txLen == 4'(el), "R10 length", txLen, el);
    @(negedge clk);
    check(txValid && txIdx == 5'(idx), "R7 hold", txIdx, idx);
    txReady = 1'b1;
    @(negedge clk);
    txReady = 1'b0;
    check(!txValid, "R6 in flight", txValid, 0);
    @(negedge clk);
    txDone = 1'b1;
    if (clash) begin
      reqSetWe = 1'b1; reqSetMask = 32'(1) << idx;
      ackClrWe = 1'b1; ackClrMask = 32'(1) << idx;
    end
    @(negedge clk);
    txDone = 1'b0; reqSetWe = 1'b0; ackClrWe = 1'b0; reqSetMask = '0; ackClrMask = '0;
    check(ackVec[idx] == 1'b1, "R5 ack set", ackVec, 32'(1) << idx);
    check(reqVec[idx] == clash, clash ? "R11 request kept" : "R5 request cleared",
          reqVec[idx], clash);
    tsIdx = 5'(idx);
    #1;
    ts = tsData;
    if (haveLast) check(ts - lastTs == 32'(cyc - lastCyc), "R9 timestamp delta",
                        ts - lastTs, cyc - lastCyc);
    lastTs = ts; lastCyc = cyc; haveLast = 1;
  endtask

  task automatic testReset;
    check(reqVec == 0 && ackVec == 0, "R1 vectors", {reqVec, ackVec}, 0);
    check(txValid == 1'b0, "R1 txValid", txValid, 0);
    tsIdx = 5'd31; #1;
    check(tsData == 0, "R1 timestamp", tsData, 0);
    @(negedge clk);
  endtask

  task automatic testPrioOrder;
    bit [31:0] left;
    for (int i = 0; i < 32; i++) cfg(i, 1, 0, (i * 7 + 3) % 32, 8);
    setReq(32'hFFFF_FFFF);
    left = '1;
    for (int s = 0; s < 32; s++) begin
      int best = -1;
      for (int i = 0; i < 32; i++)
        if (left[i] && (best < 0 || bPrio[i] >= bPrio[best])) best = i;
      left[best] = 1'b0;
      serve(best, 0, "R3");
    end
    check(reqVec == 0 && ackVec == 32'hFFFF_FFFF, "R5 all sent once", ackVec, 32'hFFFF_FFFF);
    clrAck(32'h0000_FFFF);
    check(ackVec == 32'hFFFF_0000, "R8 write-one clear", ackVec, 32'hFFFF_0000);
    clrAck(32'hFFFF_FFFF);
  endtask

  task automatic testTies;
    for (int i = 0; i < 32; i++) cfg(i, 1, 0, 0, 8);
    setReq(32'h8001_0421);
    serve(31, 0, "R4"); serve(16, 0, "R4"); serve(10, 0, "R4");
    serve(5, 0, "R4");  serve(0, 0, "R4");
    clrAck(32'hFFFF_FFFF);
  endtask

  task automatic testElig;
    bit quiet;
    cfg(3, 0, 0, 31, 8);
    cfg(7, 1, 1, 30, 8);
    cfg(9, 1, 0, 1, 8);
    setReq((32'(1) << 3) | (32'(1) << 7) | (32'(1) << 9));
    serve(9, 0, "R2");
    quiet = 1;
    for (int k = 0; k < 10; k++) begin @(negedge clk); if (txValid) quiet = 0; end
    check(quiet, "R2 no offer of ineligible", !quiet, 0);
    check(reqVec[3] && reqVec[7] && !ackVec[3] && !ackVec[7], "R2 still pending",
          {reqVec[7], reqVec[3], ackVec[7], ackVec[3]}, 4'b1100);
    cfg(3, 1, 0, 31, 8);
    serve(3, 0, "R2");
    cfg(7, 1, 0, 30, 8);
    serve(7, 0, "R2");
    clrAck(32'hFFFF_FFFF);
  endtask

  task automatic testNoPreempt;
    int w;
    cfg(2, 1, 0, 3, 8);
    cfg(30, 1, 0, 31, 8);
    setReq(32'(1) << 2);
    w = 0;
    while (!txValid && w < 60) begin @(negedge clk); w++; end
    setReq(32'(1) << 30);
    serve(2, 0, "R6");
    serve(30, 0, "R6");
    clrAck(32'hFFFF_FFFF);
  endtask

  task automatic testLength;
    cfg(12, 1, 0, 20, 15);
    cfg(13, 1, 0, 19, 5);
    setReq((32'(1) << 12) | (32'(1) << 13));
    serve(12, 0, "R10");
    serve(13, 0, "R10");
    clrAck(32'hFFFF_FFFF);
  endtask

  task automatic testClash;
    cfg(20, 1, 0, 9, 8);
    setReq(32'(1) << 20);
    serve(20, 1, "R11");
    check(ackVec[20] == 1'b1, "R8 completion beats clear", ackVec[20], 1);
    serve(20, 0, "R11");
    check(reqVec == 0, "R11 drained", reqVec, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    cfgWe = 0; cfgIdx = 0; cfgEnable = 0; cfgDir = 0; cfgPrio = 0; cfgId = 0; cfgLen = 0;
    cfgDataLo = 0; cfgDataHi = 0; reqSetWe = 0; reqSetMask = 0; ackClrWe = 0;
    ackClrMask = 0; tsIdx = 0; txReady = 0; txDone = 0;
    for (int i = 0; i < 32; i++) begin bPrio[i] = 0; bLen[i] = 0; end
    repeat (3) @(negedge clk);
    testReset;
    rstN = 1'b1;
    @(negedge clk);
    testPrioOrder;
    testTies;
    testElig;
    testNoPreempt;
    testLength;
    testClash;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule